// File: doc/BRIEF.md
# Endian-Configurable Load/Store Lane Unit

This block connects a 32-bit register datapath to a byte-addressed 32-bit data memory. It takes the byte offset of an access within its memory word, an access size and a load/store select.

On loads, it picks the addressed byte or halfword out of the memory read word and zero-extends it to a register value. A full word passes through unchanged. On stores, it copies the source byte or halfword into every lane it could occupy. It then drives a per-lane byte-enable mask so that only the addressed lane or lane pair is written.

Byte ordering within the word is little-endian or big-endian. The mode is taken from a configuration pin while reset is held and stays fixed until the next reset. Accesses that are not naturally aligned raise an alignment flag and write nothing.

Top module: `lsu_lane_unit`

## Requirements
- R1: The endianness mode (1 = big-endian) is sampled from `big_endian_i` on clock edges while `rst_ni` is low. After reset it stays fixed and is reported on `mode_be_o`. Later changes of `big_endian_i` affect neither `mode_be_o` nor any lane mapping.
- R2: In little-endian mode, byte offset k of the word is lane k, which occupies bits 8k+7:8k.
- R3: In big-endian mode, byte offset k of the word is lane 3-k. Offset 0 therefore occupies bits 31:24.
- R4: The size encoding is 00 = byte, 01 = halfword, 10 = word. A byte load returns the addressed lane in bits 7:0 and zeros in bits 31:8.
- R5: A halfword load returns the two bytes at offsets off and off+1 in bits 15:0, with zeros above. In little-endian mode the byte at off is the low byte. In big-endian mode it is the high byte.
- R6: An aligned word load returns the memory read word unchanged in either mode.
- R7: For a byte access, `wdata_o` holds source bits 7:0 in all four lanes. A byte store enables exactly the one lane of the addressed offset.
- R8: For a halfword access, `wdata_o` holds source bits 15:0 in both halves. An aligned halfword store enables exactly the lane pair of offsets off and off+1.
- R9: For a word access, `wdata_o` equals the source data. An aligned word store enables all four lanes.
- R10: A halfword access with offset bit 0 set, or a word access with a nonzero offset, drives `align_err_o` high, all byte enables low and `ld_data_o` to zero.
- R11: When `store_i` is low, no byte enable is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; mode is sampled while low |
| big_endian_i | input | 1 | Endianness configuration pin (1 = big-endian) |
| offset_i | input | 2 | Byte offset of the access within the word |
| size_i | input | 2 | Access size: 00 byte, 01 halfword, 10 word |
| store_i | input | 1 | 1 = store, 0 = load |
| rdata_i | input | 32 | Memory read word |
| st_data_i | input | 32 | Register value to store |
| ld_data_o | output | 32 | Zero-extended load result |
| wdata_o | output | 32 | Memory write word with replicated data |
| byte_en_o | output | 4 | Per-lane write enables |
| align_err_o | output | 1 | Misaligned access flag |
| mode_be_o | output | 1 | Latched endianness mode |

## Verification
The only register in the block is the mode latch. `mode_be_o` takes the pin value on the first clock edge that sees `rst_ni` low, so the bench holds the pin steady for several edges of reset before it reads the mode. Every data, enable and alignment output is combinational in the access inputs and the latched mode, and is due in the same cycle the stimulus is applied. The bench therefore drives each access just after a falling edge and samples one nanosecond later, well before the next rising edge. The pin is deliberately flipped after reset and before the sweeps, so the lane checks that follow also show that the mode stayed held.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;
endpackage

// File: rtl/lsu_endian_latch.sv
module lsu_endian_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_i,
  output logic be_o
);
  logic be_q;

  // loads only while reset is held; no reset value on purpose
  always_ff @(posedge clk_i) begin
    if (!rst_ni) be_q <= cfg_i;
  end

  assign be_o = be_q;

  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> $stable(be_o)); // R1
endmodule

// File: rtl/lsu_lane_map.sv
module lsu_lane_map #(
  parameter int unsigned NUM_LANES = 4,
  localparam int unsigned OFF_W = $clog2(NUM_LANES)
) (
  input  logic                            be_i,
  output logic [NUM_LANES-1:0][OFF_W-1:0] lane_o
);
  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    assign lane_o[k] = be_i ? OFF_W'(NUM_LANES - 1 - k) : OFF_W'(k);
  end
endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align #(
  parameter int unsigned NUM_LANES = 4,
  parameter int unsigned BYTE_W    = 8,
  localparam int unsigned OFF_W  = $clog2(NUM_LANES),
  localparam int unsigned DATA_W = NUM_LANES * BYTE_W
) (
  input  logic                            be_i,
  input  logic                            err_i,
  input  logic [OFF_W-1:0]                off_i,
  input  logic [OFF_W:0]                  nbytes_i,
  input  logic [NUM_LANES-1:0][OFF_W-1:0] lane_i,
  input  logic [DATA_W-1:0]               rdata_i,
  output logic [DATA_W-1:0]               data_o
);
  logic [OFF_W-1:0] pos;

  // significance byte i comes from offset off+i (LE) or off+n-1-i (BE)
  always_comb begin
    data_o = '0;
    pos    = '0;
    if (!err_i) begin
      for (int i = 0; i < NUM_LANES; i++) begin
        if (i < int'(nbytes_i)) begin
          pos = off_i + OFF_W'(be_i ? (int'(nbytes_i) - 1 - i) : i);
          data_o[i*BYTE_W +: BYTE_W] = rdata_i[int'(lane_i[pos])*BYTE_W +: BYTE_W];
        end
      end
    end
  end
endmodule

// File: rtl/lsu_store_pack.sv
module lsu_store_pack #(
  parameter int unsigned NUM_LANES = 4,
  parameter int unsigned BYTE_W    = 8,
  localparam int unsigned OFF_W  = $clog2(NUM_LANES),
  localparam int unsigned DATA_W = NUM_LANES * BYTE_W
) (
  input  logic                            store_i,
  input  logic                            err_i,
  input  logic [OFF_W-1:0]                off_i,
  input  logic [OFF_W:0]                  nbytes_i,
  input  logic [NUM_LANES-1:0][OFF_W-1:0] lane_i,
  input  logic [DATA_W-1:0]               st_i,
  output logic [DATA_W-1:0]               wdata_o,
  output logic [NUM_LANES-1:0]            en_o
);
  logic [OFF_W-1:0] pos;

  // replication is endian-independent: lane L carries source byte L mod n
  always_comb begin
    for (int l = 0; l < NUM_LANES; l++) begin
      wdata_o[l*BYTE_W +: BYTE_W] = st_i[(l % int'(nbytes_i))*BYTE_W +: BYTE_W];
    end
  end

  always_comb begin
    en_o = '0;
    pos  = '0;
    if (store_i && !err_i) begin
      for (int i = 0; i < NUM_LANES; i++) begin
        if (i < int'(nbytes_i)) begin
          pos = off_i + OFF_W'(i);
          en_o[lane_i[pos]] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_lane_pkg::*;
#(
  parameter int unsigned NUM_LANES = 4,
  parameter int unsigned BYTE_W    = 8,
  localparam int unsigned OFF_W  = $clog2(NUM_LANES),
  localparam int unsigned DATA_W = NUM_LANES * BYTE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 big_endian_i,
  input  logic [OFF_W-1:0]     offset_i,
  input  logic [1:0]           size_i,
  input  logic                 store_i,
  input  logic [DATA_W-1:0]    rdata_i,
  input  logic [DATA_W-1:0]    st_data_i,
  output logic [DATA_W-1:0]    ld_data_o,
  output logic [DATA_W-1:0]    wdata_o,
  output logic [NUM_LANES-1:0] byte_en_o,
  output logic                 align_err_o,
  output logic                 mode_be_o
);
  acc_size_e                       size;
  logic [OFF_W:0]                  nbytes;
  logic                            err;
  logic                            be;
  logic [NUM_LANES-1:0][OFF_W-1:0] lane;

  assign size = acc_size_e'(size_i);

  always_comb begin
    case (size)
      SZ_BYTE: nbytes = (OFF_W+1)'(1);
      SZ_HALF: nbytes = (OFF_W+1)'(NUM_LANES / 2);
      default: nbytes = (OFF_W+1)'(NUM_LANES);
    endcase
  end

  assign err = (offset_i & OFF_W'(nbytes - 1'b1)) != '0;

  lsu_endian_latch u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cfg_i  (big_endian_i),
    .be_o   (be)
  );

  lsu_lane_map #(.NUM_LANES(NUM_LANES)) u_map (
    .be_i   (be),
    .lane_o (lane)
  );

  lsu_load_align #(.NUM_LANES(NUM_LANES), .BYTE_W(BYTE_W)) u_load (
    .be_i     (be),
    .err_i    (err),
    .off_i    (offset_i),
    .nbytes_i (nbytes),
    .lane_i   (lane),
    .rdata_i  (rdata_i),
    .data_o   (ld_data_o)
  );

  lsu_store_pack #(.NUM_LANES(NUM_LANES), .BYTE_W(BYTE_W)) u_store (
    .store_i  (store_i),
    .err_i    (err),
    .off_i    (offset_i),
    .nbytes_i (nbytes),
    .lane_i   (lane),
    .st_i     (st_data_i),
    .wdata_o  (wdata_o),
    .en_o     (byte_en_o)
  );

  assign align_err_o = err;
  assign mode_be_o   = be;

  AST_ERR_NO_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_err_o |-> byte_en_o == '0); // R10
  AST_ERR_ZERO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_err_o |-> ld_data_o == '0); // R10
  AST_HALF_ODD_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i == 2'b01 && offset_i[0]) |-> align_err_o); // R10
  AST_LOAD_NO_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !store_i |-> byte_en_o == '0); // R11
  AST_BYTE_ZEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    size_i == 2'b00 |-> ld_data_o[DATA_W-1:BYTE_W] == '0); // R4
  AST_BYTE_ONE_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_i && size_i == 2'b00) |-> $onehot0(byte_en_o) && byte_en_o != '0); // R7
  AST_WORD_ALL_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_i && size_i == 2'b10 && !align_err_o) |-> &byte_en_o); // R9
  AST_HALF_TWO_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_i && size_i == 2'b01 && !align_err_o) |-> $countones(byte_en_o) == 2); // R8
endmodule

// File: tb/lsu_lane_unit_bench.sv
`timescale 1ns/1ps
module lsu_lane_unit_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        big_endian_i = 1'b0;
  logic [1:0]  offset_i = '0;
  logic [1:0]  size_i = '0;
  logic        store_i = 1'b0;
  logic [31:0] rdata_i = '0;
  logic [31:0] st_data_i = '0;
  logic [31:0] ld_data_o, wdata_o;
  logic [3:0]  byte_en_o;
  logic        align_err_o, mode_be_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lsu_lane_unit u_lsu_lane_unit (
    .clk_i(clk), .rst_ni(rst_ni), .big_endian_i(big_endian_i),
    .offset_i(offset_i), .size_i(size_i), .store_i(store_i),
    .rdata_i(rdata_i), .st_data_i(st_data_i), .ld_data_o(ld_data_o),
    .wdata_o(wdata_o), .byte_en_o(byte_en_o), .align_err_o(align_err_o),
    .mode_be_o(mode_be_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_access(input bit be, input int off, input int sz, input bit st,
                            input logic [31:0] rd, input logic [31:0] sd);
    int nb, sh;
    bit err;
    logic [63:0] lexp;
    logic [31:0] wexp;
    logic [3:0]  eexp;
    string lt, et, wt;
    @(negedge clk);
    offset_i = 2'(off); size_i = 2'(sz); store_i = st; rdata_i = rd; st_data_i = sd;
    #1;
    nb  = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    err = (off % nb) != 0;
    sh  = be ? (4 - off - nb) : off;
    lexp = err ? 64'd0 : ((64'(rd) >> (8 * sh)) & ((64'd1 << (8 * nb)) - 1));
    eexp = (err || !st) ? 4'd0 : 4'(((1 << nb) - 1) << sh);
    wexp = (nb == 1) ? {4{sd[7:0]}} : (nb == 2) ? {2{sd[15:0]}} : sd;
    if (err) lt = "R10";
    else if (sz == 0) lt = be ? "R3 R4" : "R2 R4";
    else if (sz == 1) lt = "R5";
    else lt = "R6";
    if (!st) et = "R11";
    else if (err) et = "R10";
    else if (sz == 0) et = be ? "R7 R3" : "R7 R2";
    else if (sz == 1) et = "R8";
    else et = "R9";
    wt = (sz == 0) ? "R7" : (sz == 1) ? "R8" : "R9";
    check(lt, ld_data_o, lexp[31:0]);
    check(et, 32'(byte_en_o), 32'(eexp));
    check(wt, wdata_o, wexp);
    check("R10", 32'(align_err_o), 32'(err));
  endtask

  initial begin
    logic [31:0] pat [4];
    logic [31:0] lfsr;
    pat[0] = 32'h8196_A5F3; pat[1] = 32'h0123_4567;
    pat[2] = 32'hFFFF_FFFF; pat[3] = 32'h7E00_C3A9;
    lfsr = 32'hACE1_2345;
    for (int m = 0; m < 2; m++) begin
      rst_ni = 1'b0;
      big_endian_i = m[0];
      store_i = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", 32'(mode_be_o), 32'(m));
      check("R11", 32'(byte_en_o), 32'd0);
      rst_ni = 1'b1;
      @(negedge clk);
      big_endian_i = ~m[0];
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", 32'(mode_be_o), 32'(m));
      for (int p = 0; p < 4; p++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        for (int off = 0; off < 4; off++)
          for (int sz = 0; sz < 3; sz++)
            for (int st = 0; st < 2; st++)
              run_access(m[0], off, sz, st[0], pat[p], lfsr ^ pat[3 - p]);
      end
      check("R1", 32'(mode_be_o), 32'(m));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule